// File: doc/BRIEF.md
# Programmable Interval Timer

The block is a 32-bit interval timer that counts down and sits behind a small word-addressed register bus. Software loads a timeout period as two 16-bit halves, then issues start and stop commands through the control word and chooses whether the timer fires once or repeatedly. Each time the count runs out, the timer sets a timeout flag and reloads itself from the period. If the interrupt is enabled, it raises a level interrupt that stays high until software acknowledges it.

The live count cannot be read directly while it changes. Software first writes either snapshot word, which freezes the current count into a holding register, and then reads the two snapshot halves at leisure. Reads are combinational from the selected word. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `interval_timer`

## Requirements
- R1: Byte-address bits [4:2] select one of eight words. Words 0 to 5 are status, control, period-low, period-high, snapshot-low and snapshot-high. Words 6 and 7 read as zero, and writes to them change nothing.
- R2: After reset every word reads zero, the timer is stopped and `irq` is low.
- R3: Control keeps only bit 0 (interrupt enable) and bit 1 (continuous mode). Bit 2 (start) and bit 3 (stop) act as commands and always read back as zero.
- R4: Any write to status clears the timeout flag (status bit 0), whatever the data. If an expiry happens in the same cycle, the flag is set instead.
- R5: A start command on a stopped timer sets the running flag (status bit 1) and counting begins. A start on a running timer changes neither the count nor the running flag.
- R6: A stop command on a running timer clears the running flag and freezes the count. If start and stop arrive in one write, the timer ends up stopped.
- R7: Each period word stores the low 16 bits of the write data. Writing either half stops the timer and loads the counter with the new 32-bit period {high, low}.
- R8: With period P, the timeout flag rises on the (P+1)-th rising edge after the edge that accepted the start command.
- R9: On expiry in one-shot mode the timeout flag is set, the running flag clears, and the counter is reloaded with the period.
- R10: In continuous mode the timer reloads and keeps running, so it expires every P+1 cycles.
- R11: A write to either snapshot word captures the count present before that edge. Snapshot-low returns bits [15:0] and snapshot-high returns bits [31:16].
- R12: `irq` is high exactly when the timeout flag and the interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Byte address; bits [4:2] pick the word |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
Read data and `irq` are combinational from the registers. A write's effect therefore shows in the cycle right after its accepting edge. An expiry shows P+1 edges after the start edge. A snapshot holds the count from one edge before the capture. The bench drives each bus operation at the falling edge and samples `rdata` and `irq` shortly after, before the next rising edge. It then advances its reference model exactly one edge. As a result, every comparison is made against the state reached after the preceding rising edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned HALF_W = CNT_W / 2;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned NWORDS = 1 << IDX_W;

  localparam logic [IDX_W-1:0] IX_STATUS = 3'd0;
  localparam logic [IDX_W-1:0] IX_CTRL   = 3'd1;
  localparam logic [IDX_W-1:0] IX_PER_LO = 3'd2;
  localparam logic [IDX_W-1:0] IX_PER_HI = 3'd3;
  localparam logic [IDX_W-1:0] IX_SNP_LO = 3'd4;
  localparam logic [IDX_W-1:0] IX_SNP_HI = 3'd5;

  localparam int unsigned S_TO    = 0;
  localparam int unsigned S_RUN   = 1;
  localparam int unsigned C_IEN   = 0;
  localparam int unsigned C_CONT  = 1;
  localparam int unsigned C_START = 2;
  localparam int unsigned C_STOP  = 3;

  function automatic logic [CNT_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                   input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] cur,
                                                   input logic [CNT_W-1:0] reload);
    return (cur == '0) ? reload : cur - CNT_W'(1);
  endfunction

  function automatic logic run_next(input logic run, input logic per_wr,
                                    input logic stop, input logic start,
                                    input logic expired, input logic cont);
    if (per_wr || stop)     return 1'b0;
    if (start && !run)      return 1'b1;
    if (expired && !cont)   return 1'b0;
    return run;
  endfunction
endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
  import ivt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic [IDX_W-1:0]  idx,
  output logic [NWORDS-1:0] wr_sel
);
  localparam int unsigned IDX_LSB = 2;

  assign idx = addr[IDX_W+IDX_LSB-1:IDX_LSB];

  for (genvar i = 0; i < NWORDS; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (idx == IDX_W'(i));
  end

  logic unused_lsb;
  assign unused_lsb = ^addr[IDX_LSB-1:0];

  if (ADDR_W > IDX_W + IDX_LSB) begin : g_upper
    logic unused_upper;
    assign unused_upper = ^addr[ADDR_W-1:IDX_W+IDX_LSB];
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             at_zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= reload_val;
    else if (step) count <= count_after(count, reload_val);
  end

  assign at_zero = (count == '0);

  // R8: a running, non-expiring count drops by one per edge
  a_r8_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !at_zero) |=> count == $past(count) - CNT_W'(1));
  // R7: a period write loads the new period
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(reload_val));
  // R6: a stopped counter holds its value
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(count));
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWORDS-1:0] wr_sel,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              at_zero,
  output logic              cnt_load,
  output logic              cnt_step,
  output logic [CNT_W-1:0]  period_nxt,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic              to_flag, running, ien, cont;
  logic [HALF_W-1:0] per_lo, per_hi, per_lo_n, per_hi_n;
  logic [CNT_W-1:0]  snap;

  // named internal events
  logic wr_status, wr_ctrl, wr_per_lo, wr_per_hi, wr_per, wr_snap;
  logic cmd_start, cmd_stop, halt_req, expire;

  assign wr_status = wr_sel[IX_STATUS];
  assign wr_ctrl   = wr_sel[IX_CTRL];
  assign wr_per_lo = wr_sel[IX_PER_LO];
  assign wr_per_hi = wr_sel[IX_PER_HI];
  assign wr_per    = wr_per_lo || wr_per_hi;
  assign wr_snap   = wr_sel[IX_SNP_LO] || wr_sel[IX_SNP_HI];
  assign cmd_start = wr_ctrl && wdata[C_START];
  assign cmd_stop  = wr_ctrl && wdata[C_STOP];
  assign halt_req  = wr_per || cmd_stop;
  assign cnt_step  = running && !halt_req;
  assign expire    = cnt_step && at_zero;
  assign cnt_load  = wr_per;

  assign per_lo_n   = wr_per_lo ? wdata[HALF_W-1:0] : per_lo;
  assign per_hi_n   = wr_per_hi ? wdata[HALF_W-1:0] : per_hi;
  assign period_nxt = join_halves(per_hi_n, per_lo_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_flag <= 1'b0;
      running <= 1'b0;
      ien     <= 1'b0;
      cont    <= 1'b0;
      per_lo  <= '0;
      per_hi  <= '0;
      snap    <= '0;
    end else begin
      if (wr_ctrl) begin
        ien  <= wdata[C_IEN];
        cont <= wdata[C_CONT];
      end
      per_lo <= per_lo_n;
      per_hi <= per_hi_n;
      if (wr_snap) snap <= count;
      if (expire)         to_flag <= 1'b1;
      else if (wr_status) to_flag <= 1'b0;
      running <= run_next(running, wr_per, cmd_stop, cmd_start, expire, cont);
    end
  end

  assign irq = to_flag && ien;

  always_comb begin
    rdata = '0;
    case (rd_idx)
      IX_STATUS: begin
        rdata[S_TO]  = to_flag;
        rdata[S_RUN] = running;
      end
      IX_CTRL: begin
        rdata[C_IEN]  = ien;
        rdata[C_CONT] = cont;
      end
      IX_PER_LO: rdata[HALF_W-1:0] = per_lo;
      IX_PER_HI: rdata[HALF_W-1:0] = per_hi;
      IX_SNP_LO: rdata[HALF_W-1:0] = snap[HALF_W-1:0];
      IX_SNP_HI: rdata[HALF_W-1:0] = snap[CNT_W-1:HALF_W];
      default:   rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:HALF_W];

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
  a_r5_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_stop && !running) |=> running);
  a_r6_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !running);
  a_r7_period_halts: assert property (@(posedge clk) disable iff (!rst_n)
    wr_per |=> !running);
  a_r9_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> to_flag);
  a_r9_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cont) |=> !running);
  a_r10_cont_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cont) |=> running);
  a_r4_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !expire) |=> !to_flag);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import ivt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [IDX_W-1:0]  idx;
  logic [NWORDS-1:0] wr_sel;
  logic              cnt_load, cnt_step, at_zero;
  logic [CNT_W-1:0]  period_nxt, count;

  ivt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (addr),
    .wr_en  (wr_en),
    .idx    (idx),
    .wr_sel (wr_sel)
  );

  ivt_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sel     (wr_sel),
    .rd_idx     (idx),
    .wdata      (wdata),
    .count      (count),
    .at_zero    (at_zero),
    .cnt_load   (cnt_load),
    .cnt_step   (cnt_step),
    .period_nxt (period_nxt),
    .rdata      (rdata),
    .irq        (irq)
  );

  ivt_counter u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cnt_load),
    .step       (cnt_step),
    .reload_val (period_nxt),
    .count      (count),
    .at_zero    (at_zero)
  );
endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;
  localparam int N_RANDOM   = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic last_irq;

  // reference state
  logic        m_to, m_run, m_ien, m_cont;
  logic [15:0] m_pl, m_ph;
  logic [31:0] m_cnt, m_snap;

  task automatic model_reset();
    m_to = 0; m_run = 0; m_ien = 0; m_cont = 0;
    m_pl = '0; m_ph = '0; m_cnt = '0; m_snap = '0;
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] ix);
    case (ix)
      3'd0: return {30'd0, m_run, m_to};
      3'd1: return {30'd0, m_cont, m_ien};
      3'd2: return {16'd0, m_pl};
      3'd3: return {16'd0, m_ph};
      3'd4: return {16'd0, m_snap[15:0]};
      3'd5: return {16'd0, m_snap[31:16]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] ix);
    case (ix)
      3'd0: return "R9 status";
      3'd1: return "R3 control";
      3'd2, 3'd3: return "R7 period";
      3'd4, 3'd5: return "R11 snapshot";
      default: return "R1 unimplemented";
    endcase
  endfunction

  task automatic model_edge(input logic [4:0] a, input logic we, input logic [31:0] d);
    logic [2:0]  ix;
    logic        w_st, w_ct, w_pl, w_ph, w_sn, wp, sta, stp, adv, fire;
    logic [15:0] npl, nph;
    logic [31:0] per;
    ix   = a[4:2];
    w_st = we && ix == 3'd0;
    w_ct = we && ix == 3'd1;
    w_pl = we && ix == 3'd2;
    w_ph = we && ix == 3'd3;
    w_sn = we && (ix == 3'd4 || ix == 3'd5);
    wp   = w_pl || w_ph;
    sta  = w_ct && d[2];
    stp  = w_ct && d[3];
    npl  = w_pl ? d[15:0] : m_pl;
    nph  = w_ph ? d[15:0] : m_ph;
    per  = {nph, npl};
    adv  = m_run && !wp && !stp;
    fire = adv && m_cnt == 0;
    if (w_sn) m_snap = m_cnt;
    if (wp)       m_cnt = per;
    else if (adv) m_cnt = (m_cnt == 0) ? per : m_cnt - 1;
    if (wp || stp)        m_run = 0;
    else if (sta && !m_run) m_run = 1;
    else if (fire && !m_cont) m_run = 0;
    if (fire)      m_to = 1;
    else if (w_st) m_to = 0;
    if (w_ct) begin m_ien = d[0]; m_cont = d[1]; end
    m_pl = npl;
    m_ph = nph;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, sample, then advance the model one edge
  task automatic cycle(input logic [2:0] ix, input logic we, input logic [31:0] d,
                       input string tag);
    @(negedge clk);
    addr = {ix, 2'b00}; wr_en = we; wdata = d;
    #1;
    last_irq = irq;
    chk("R12 irq", {31'd0, irq}, {31'd0, m_to & m_ien});
    if (!we) chk(tag, rdata, m_read(ix));
    @(posedge clk);
    model_edge({ix, 2'b00}, we, d);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > MAX_CYCLES) begin
        errors++;
        $display("FAIL watchdog (all) actual=%0d expected<=%0d", cycles, MAX_CYCLES);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state of every word
    for (int i = 0; i < 8; i++) cycle(3'(i), 1'b0, 32'd0, "R2 reset");
    chk("R2 irq after reset", {31'd0, last_irq}, 32'd0);

    // R6: start and stop together leave it stopped; R3 command bits not stored
    cycle(3'd1, 1'b1, 32'hFFFF_FFFF, "");
    cycle(3'd0, 1'b0, 0, "R6 start+stop");
    chk("R6 literal", m_read(3'd0), 32'd0);
    cycle(3'd1, 1'b0, 0, "R3 control readback");

    // R7: only 16 bits stored
    cycle(3'd2, 1'b1, 32'hABCD_0004, "");
    cycle(3'd2, 1'b0, 0, "R7 period low");
    cycle(3'd3, 1'b1, 32'h1234_0000, "");

    // R8/R9: one-shot with P=4, ien set
    cycle(3'd1, 1'b1, 32'h5, "");
    for (int i = 0; i < 5; i++) cycle(3'd0, 1'b0, 0, "R8 one-shot timing");
    chk("R8 irq low before P+1", {31'd0, last_irq}, 32'd0);
    cycle(3'd0, 1'b0, 0, "R9 one-shot expiry");
    chk("R8 irq high at P+1", {31'd0, last_irq}, 32'd1);
    cycle(3'd4, 1'b1, 0, "");
    cycle(3'd4, 1'b0, 0, "R9 reload snapshot");
    chk("R9 literal reload", m_read(3'd4), 32'd4);

    // R4: status write with arbitrary data clears the flag
    cycle(3'd0, 1'b1, 32'h0, "");
    cycle(3'd0, 1'b0, 0, "R4 status clear");

    // R10: continuous, P=2
    cycle(3'd2, 1'b1, 32'd2, "");
    cycle(3'd1, 1'b1, 32'h7, "");
    for (int i = 0; i < 8; i++) cycle(3'd0, 1'b0, 0, "R10 continuous");
    // R5: start while running ignored
    cycle(3'd1, 1'b1, 32'h6, "");
    cycle(3'd5, 1'b1, 0, "");
    cycle(3'd4, 1'b0, 0, "R5 start while running");
    // R6: stop freezes count
    cycle(3'd1, 1'b1, 32'h8, "");
    cycle(3'd4, 1'b1, 0, "");
    cycle(3'd0, 1'b0, 0, "R6 stop");
    cycle(3'd4, 1'b1, 0, "");
    cycle(3'd4, 1'b0, 0, "R6 count frozen");
    // R1: unimplemented words
    cycle(3'd6, 1'b1, 32'hFFFF_FFFF, "");
    cycle(3'd7, 1'b1, 32'hFFFF_FFFF, "");
    for (int i = 0; i < 8; i++) cycle(3'(i), 1'b0, 0, tag_for(3'(i)));
    // R11: large period, snapshot high half
    cycle(3'd3, 1'b1, 32'hFFFF_0001, "");
    cycle(3'd1, 1'b1, 32'h4, "");
    cycle(3'd5, 1'b1, 0, "");
    cycle(3'd5, 1'b0, 0, "R11 snapshot high");
    cycle(3'd3, 1'b1, 32'd0, "");

    // constrained random
    for (int n = 0; n < N_RANDOM; n++) begin
      logic [2:0]  ix;
      logic        we;
      logic [31:0] d;
      ix = 3'($urandom_range(0, 7));
      we = ($urandom_range(0, 9) < 4);
      d  = $urandom;
      if (ix == 3'd2) d = (d & 32'hFFFF_0000) | 32'($urandom_range(0, 6));
      if (ix == 3'd3) d = (d & 32'hFFFF_0000) | (($urandom_range(0, 15) == 0) ? 32'd1 : 32'd0);
      if (ix == 3'd0 && we && $urandom_range(0, 3) != 0) we = 1'b0;
      cycle(ix, we, d, tag_for(ix));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule